// File: doc/BRIEF.md
# Exact Floating-Point Multiplier

This block multiplies two floating-point operands, each presented as a sign bit, a biased exponent field and a fraction field, and hands back the complete product without any rounding. The exponent of the result is one bit wider than the input exponents, and the significand is twice the input significand width (hidden one included). Because nothing is normalized, the leading one of a non-zero product lands in one of the two most significant significand bits. The intended consumer is the input aligner of a wide fixed-point accumulator, which shifts the significand into place using the exponent, so dropping product bits would only lose accuracy there.

Operands enter and results leave over valid/ready streams. A configurable number of register stages sits between the arithmetic and the output. All stages advance together whenever the output slot is empty or is being taken. Back-pressure rules:
- A producer may change operands only after `in_valid && in_ready` was seen at a clock edge.
- While `out_valid` is high and `out_ready` is low, the result fields and `out_valid` stay frozen.
- `in_ready` drops only when the output holds a result that is not being taken.

Infinities, NaNs and subnormals are not treated specially. An exponent field of zero marks an operand as zero.

Top module: `exact_fp_mul`

## Requirements
- R1: `out_sign` is the XOR of the two operand sign bits, including when the product is zero.
- R2: For non-zero operands, `out_exp` equals (ea + eb − (2^(WE−1) − 1)) modulo 2^(WE+1), where ea and eb are the unsigned exponent fields.
- R3: For non-zero operands, `out_sig` equals the integer product of {1, fa} and {1, fb}, 2·WF+2 bits, with no bit dropped.
- R4: When `out_valid` is high and `out_zero` is low, at least one of the two most significant bits of `out_sig` is 1.
- R5: When either exponent field is 0, `out_zero` is 1 and both `out_sig` and `out_exp` are 0. Otherwise `out_zero` is 0.
- R6: With `out_ready` held high, a result accepted at a clock edge appears on `out_valid` exactly STAGES clock edges later (same cycle when STAGES is 0).
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and all result fields unchanged.
- R8: When STAGES > 0, `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. Results leave in the order operands were accepted, and none is lost or duplicated.
- R9: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block accepts the operand pair this cycle |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | WE | Biased exponent of operand A |
| a_frac | input | WF | Fraction of operand A |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | WE | Biased exponent of operand B |
| b_frac | input | WF | Fraction of operand B |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sign | output | 1 | Product sign |
| out_zero | output | 1 | Product is zero |
| out_exp | output | WE+1 | Product exponent, biased once |
| out_sig | output | 2*WF+2 | Unrounded product significand |

## Verification
The bench sweeps every operand pair of a 3-bit-exponent, 2-bit-fraction configuration. Back-pressure comes from a pseudo-random `out_ready` pattern.

A design that truncated or rounded the significand would differ in its low bits. One that renormalized would move the leading one and change the exponent by one. One that subtracted the bias in too narrow a field would wrap wrongly when both exponents are large or their sum falls below the bias.

Zero operands paired with every other value catch a flag that ignores one side, and catch a design that forgets to clear the significand or exponent. Stalls held for several cycles expose results that change or vanish under back-pressure. A directed single transfer measures the pipeline latency.

// File: rtl/exact_fp_mul_pkg.sv
package exact_fp_mul_pkg;

  // Exponent bias of an IEEE-style format with an exponent field of width we.
  function automatic int unsigned exp_bias(input int unsigned we);
    return (32'd1 << (we - 1)) - 32'd1;
  endfunction

  // Width of the full product significand for a given fraction width.
  function automatic int unsigned prod_width(input int unsigned wf);
    return 2 * wf + 2;
  endfunction

endpackage

// File: rtl/exact_fp_mul_sigmul.sv
// Full-width product of two significands carrying their hidden one.
module exact_fp_mul_sigmul #(
  parameter int unsigned WF        = 23,
  parameter bit          ARRAY_MUL = 1'b0
) (
  input  logic [WF-1:0]     frac_a,
  input  logic [WF-1:0]     frac_b,
  output logic [2*WF+1:0]   product
);
  localparam int unsigned MW = WF + 1;
  localparam int unsigned PW = 2 * MW;

  logic [MW-1:0] man_a;
  logic [MW-1:0] man_b;

  assign man_a = {1'b1, frac_a};
  assign man_b = {1'b1, frac_b};

  generate
    if (ARRAY_MUL) begin : g_array
      // Shift-and-add of partial products, one row per multiplier bit.
      logic [PW-1:0] rows [MW];
      for (genvar i = 0; i < MW; i++) begin : g_row
        assign rows[i] = man_b[i] ? ({{MW{1'b0}}, man_a} << i) : '0;
      end
      always_comb begin
        product = '0;
        for (int k = 0; k < MW; k++) begin
          product = product + rows[k];
        end
      end
    end else begin : g_infer
      assign product = PW'(man_a) * PW'(man_b);
    end
  endgenerate

endmodule

// File: rtl/exact_fp_mul_core.sv
// Combinational datapath: sign, exponent sum, zero detection and significand.
module exact_fp_mul_core
  import exact_fp_mul_pkg::*;
#(
  parameter int unsigned WE        = 8,
  parameter int unsigned WF        = 23,
  parameter bit          ARRAY_MUL = 1'b0
) (
  input  logic              a_sign,
  input  logic [WE-1:0]     a_exp,
  input  logic [WF-1:0]     a_frac,
  input  logic              b_sign,
  input  logic [WE-1:0]     b_exp,
  input  logic [WF-1:0]     b_frac,
  output logic              p_sign,
  output logic              p_zero,
  output logic [WE:0]       p_exp,
  output logic [2*WF+1:0]   p_sig
);
  localparam int unsigned XW   = WE + 1;
  localparam logic [XW-1:0] BIAS = XW'(exp_bias(WE));

  logic [2*WF+1:0] raw_sig;
  logic [XW-1:0]   exp_sum;

  exact_fp_mul_sigmul #(
    .WF        (WF),
    .ARRAY_MUL (ARRAY_MUL)
  ) u_sigmul (
    .frac_a  (a_frac),
    .frac_b  (b_frac),
    .product (raw_sig)
  );

  assign exp_sum = {1'b0, a_exp} + {1'b0, b_exp};

  always_comb begin
    p_sign = a_sign ^ b_sign;
    p_zero = (a_exp == '0) || (b_exp == '0);
    if (p_zero) begin
      p_exp = '0;
      p_sig = '0;
    end else begin
      p_exp = exp_sum - BIAS;
      p_sig = raw_sig;
    end
  end

endmodule

// File: rtl/exact_fp_mul_pipe.sv
// Register chain with a common advance enable driven by the output slot.
module exact_fp_mul_pipe #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data
);
  generate
    if (STAGES == 0) begin : g_wire
      assign out_valid = in_valid;
      assign out_data  = in_data;
      assign in_ready  = out_ready;
    end else begin : g_regs
      logic [W-1:0] dq [STAGES];
      logic         vq [STAGES];
      logic         advance;

      assign advance   = !vq[STAGES-1] || out_ready;
      assign in_ready  = advance;
      assign out_valid = vq[STAGES-1];
      assign out_data  = dq[STAGES-1];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < STAGES; s++) begin
            vq[s] <= 1'b0;
            dq[s] <= '0;
          end
        end else if (advance) begin
          vq[0] <= in_valid;
          dq[0] <= in_data;
          for (int s = 1; s < STAGES; s++) begin
            vq[s] <= vq[s-1];
            dq[s] <= dq[s-1];
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/exact_fp_mul.sv
module exact_fp_mul
  import exact_fp_mul_pkg::*;
#(
  parameter int unsigned WE        = 8,
  parameter int unsigned WF        = 23,
  parameter int unsigned STAGES    = 1,
  parameter bit          ARRAY_MUL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              a_sign,
  input  logic [WE-1:0]     a_exp,
  input  logic [WF-1:0]     a_frac,
  input  logic              b_sign,
  input  logic [WE-1:0]     b_exp,
  input  logic [WF-1:0]     b_frac,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sign,
  output logic              out_zero,
  output logic [WE:0]       out_exp,
  output logic [2*WF+1:0]   out_sig
);
  localparam int unsigned SW = prod_width(WF);
  localparam int unsigned XW = WE + 1;
  localparam int unsigned PW = 2 + XW + SW;

  logic          c_sign;
  logic          c_zero;
  logic [XW-1:0] c_exp;
  logic [SW-1:0] c_sig;
  logic [PW-1:0] stage_in;
  logic [PW-1:0] stage_out;

  exact_fp_mul_core #(
    .WE        (WE),
    .WF        (WF),
    .ARRAY_MUL (ARRAY_MUL)
  ) u_core (
    .a_sign (a_sign),
    .a_exp  (a_exp),
    .a_frac (a_frac),
    .b_sign (b_sign),
    .b_exp  (b_exp),
    .b_frac (b_frac),
    .p_sign (c_sign),
    .p_zero (c_zero),
    .p_exp  (c_exp),
    .p_sig  (c_sig)
  );

  assign stage_in = {c_sign, c_zero, c_exp, c_sig};

  exact_fp_mul_pipe #(
    .W      (PW),
    .STAGES (STAGES)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (stage_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (stage_out)
  );

  assign out_sign = stage_out[PW-1];
  assign out_zero = stage_out[PW-2];
  assign out_exp  = stage_out[SW +: XW];
  assign out_sig  = stage_out[SW-1:0];

endmodule

// File: rtl/exact_fp_mul_chk.sv
module exact_fp_mul_chk #(
  parameter int unsigned WE     = 8,
  parameter int unsigned WF     = 23,
  parameter int unsigned STAGES = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sign,
  input logic              out_zero,
  input logic [WE:0]       out_exp,
  input logic [2*WF+1:0]   out_sig
);
  localparam int unsigned SW = 2 * WF + 2;

  // R4: unnormalized product keeps its leading one in the top two bits
  a_r4_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_zero) |-> (out_sig[SW-1] || out_sig[SW-2]));

  // R5: a zero product carries cleared significand and exponent
  a_r5_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_sig == '0 && out_exp == '0));

  generate
    if (STAGES > 0) begin : g_reg_checks
      // R7: stalled result stays put
      a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
          (out_valid && $stable(out_sig) && $stable(out_exp)
           && $stable(out_zero) && $stable(out_sign)));

      // R8: input is refused only behind a blocked output
      a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));

      // R9: first cycle out of reset shows an empty output
      a_r9_reset_empty: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid);
    end
  endgenerate

endmodule

bind exact_fp_mul exact_fp_mul_chk #(
  .WE     (WE),
  .WF     (WF),
  .STAGES (STAGES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sign  (out_sign),
  .out_zero  (out_zero),
  .out_exp   (out_exp),
  .out_sig   (out_sig)
);

// File: tb/sim_exact_fp_mul.sv
`timescale 1ns/1ps
module sim_exact_fp_mul;
  localparam int WE = 3;
  localparam int WF = 2;
  localparam int ST = 2;
  localparam int SW = 2 * WF + 2;
  localparam int XW = WE + 1;
  localparam int RW = 2 + XW + SW;
  localparam int BIAS = (1 << (WE - 1)) - 1;
  localparam int OPW = 1 + WE + WF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [WE-1:0] a_exp = '0, b_exp = '0;
  logic [WF-1:0] a_frac = '0, b_frac = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_sign, out_zero;
  logic [XW-1:0] out_exp;
  logic [SW-1:0] out_sig;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [RW-1:0] expq [$];

  always #10 clk = ~clk;

  exact_fp_mul #(.WE(WE), .WF(WF), .STAGES(ST), .ARRAY_MUL(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
    .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sign(out_sign), .out_zero(out_zero), .out_exp(out_exp), .out_sig(out_sig)
  );

  function automatic logic [RW-1:0] model(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    int ea, eb, fa, fb, e, m;
    logic s, z;
    s  = a[OPW-1] ^ b[OPW-1];
    ea = int'(a[WF +: WE]);
    eb = int'(b[WF +: WE]);
    fa = int'(a[WF-1:0]) + (1 << WF);
    fb = int'(b[WF-1:0]) + (1 << WF);
    z  = (ea == 0) || (eb == 0);
    e  = z ? 0 : ((ea + eb - BIAS) % (1 << XW) + (1 << XW)) % (1 << XW);
    m  = z ? 0 : fa * fb;
    return {s, z, XW'(e), SW'(m)};
  endfunction

  function automatic logic [RW-1:0] seen();
    return {out_sign, out_zero, out_exp, out_sig};
  endfunction

  task automatic check(input bit ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic set_ops(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    {a_sign, a_exp, a_frac} = a;
    {b_sign, b_exp, b_frac} = b;
  endtask

  task automatic compare_result(input logic [RW-1:0] e);
    logic [RW-1:0] g;
    g = seen();
    check(g[RW-1] == e[RW-1], "R1 sign", g, e);
    check(g[RW-2] == e[RW-2], "R5 zero flag", g, e);
    check(g[SW +: XW] == e[SW +: XW], "R2 exponent", g, e);
    check(g[SW-1:0] == e[SW-1:0], "R3 significand", g, e);
    if (!e[RW-2])
      check(g[SW-1] || g[SW-2], "R4 leading one", g, e);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lfsr;
    int idx;
    int lat;
    bit held;
    logic [RW-1:0] held_v;
    logic [RW-1:0] e;

    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid in reset", RW'(out_valid), '0);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9 after reset", RW'({out_valid, in_ready}), RW'(1));

    // R6: latency of a single transfer with out_ready high
    set_ops({1'b1, 3'd5, 2'd3}, {1'b0, 3'd6, 2'd1});
    e = model({1'b1, 3'd5, 2'd3}, {1'b0, 3'd6, 2'd1});
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 10) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    check(lat == ST, "R6 latency", RW'(lat), RW'(ST));
    compare_result(e);
    @(posedge clk);
    @(negedge clk);

    // Exhaustive sweep with pseudo-random back-pressure
    lfsr = 32'h1ACE;
    idx = 0;
    held = 1'b0;
    held_v = '0;
    while (idx < (1 << (2 * OPW)) || expq.size() != 0) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      out_ready = (lfsr[2:0] != 3'd0) && !(lfsr[4] && lfsr[5]);
      in_valid = (idx < (1 << (2 * OPW)));
      set_ops(OPW'(idx >> OPW), OPW'(idx));
      #1;
      if (held) begin
        check(out_valid && seen() == held_v, "R7 stall hold", seen(), held_v);
      end
      check(in_ready == (!out_valid || out_ready), "R8 ready rule", RW'(in_ready), RW'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R8 extra result", seen(), '0);
        end else begin
          compare_result(expq.pop_front());
        end
      end
      held = out_valid && !out_ready;
      held_v = seen();
      if (in_valid && in_ready) begin
        expq.push_back(model(OPW'(idx >> OPW), OPW'(idx)));
        idx++;
      end
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (ST + 2) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 no duplicate after drain", RW'(out_valid), '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule